// File: doc/BRIEF.md
# Dual-Threshold Pilot Code Detector

This block looks for a periodic pilot made of back-to-back, unmodulated repetitions of a 31-chip maximal-length code. Up to three sample-phase streams of signed I/Q chips enter in parallel under a shared valid strobe. Each stream goes through its own matched filter with fixed ±1 taps. The filter output is reduced to a magnitude of |I|+|Q|, so the result does not depend on the carrier phase.

A per-stream test then declares a pilot when three conditions all hold:
- a correlation magnitude rises above a high threshold;
- the magnitudes at the 30 positions that follow add up to less than a low threshold;
- exactly one code period after the first peak, a second magnitude again rises above the high threshold.

Both thresholds are formed from a received-power estimate by shift-and-add scaling. They are re-captured once per code period.

On a detection the block emits a one-cycle pulse. With it come the index of the stream that fired and the chip position of the second peak. When several streams fire together, the stream with the strongest second peak is reported. The detection latency is a small fraction of the 10 to 15 code repetitions that make up the pilot.

Top module: `pilot_detector`

## Requirements
- R1: While rst_ni is low and after its release until the first detection, detect_o, stream_o and peak_pos_o are all 0.
- R2: Each stream correlates its last 31 valid samples against the code c[0..30]. The code is produced by a 5-bit state s initialised to 00001: each step outputs s[0], then shifts right with s[0]^s[2] entering at s[4]. A code bit of 1 weights by +1 and a bit of 0 weights by -1. The oldest sample meets c[0], so a full, aligned code of amplitude A gives a magnitude of 31·A.
- R3: The magnitude is |corr_I| + |corr_Q|. A pilot carried on Q only, or with negated or split I/Q amplitudes of the same total, is detected the same way.
- R4: A first peak needs a magnitude strictly greater than the high threshold. A magnitude equal to it starts nothing.
- R5: The magnitudes at the 30 valid samples strictly between the two peaks are summed. Detection requires that sum to be strictly less than the low threshold.
- R6: The second peak must be the 31st valid sample after the first and must strictly exceed the high threshold. Whether that sample passes or fails, the stream returns to searching, and the sample is not taken as a new first peak.
- R7: detect_o pulses in the second cycle after the clock edge that takes in the second-peak sample. peak_pos_o carries that sample's chip position, which is the number of valid samples since reset, modulo 31.
- R8: Cycles with valid_i low are ignored. Data presented on them neither enters the filters nor advances the chip position.
- R9: The high threshold is (pwr_i<<hi_sh_a_i)+(pwr_i<<hi_sh_b_i). The low threshold is (pwr_i<<lo_sh_a_i)+(pwr_i<<lo_sh_b_i).
- R10: Thresholds are captured once per code period, in the cycle after the sample at chip position 30 is taken in. The new values apply from chip position 0 of the next period. A change in the power estimate during a period has no effect before then.
- R11: When several streams fire on the same sample, the one with the largest second-peak magnitude is reported. On a tie, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One chip sample per stream this cycle |
| i_data_i | input | NUM_STREAMS*SAMPLE_W | Signed in-phase samples, stream 0 in the low bits |
| q_data_i | input | NUM_STREAMS*SAMPLE_W | Signed quadrature samples, stream 0 in the low bits |
| pwr_i | input | PWR_W | Received-power estimate |
| hi_sh_a_i | input | SH_W | First shift term of the high threshold |
| hi_sh_b_i | input | SH_W | Second shift term of the high threshold |
| lo_sh_a_i | input | SH_W | First shift term of the low threshold |
| lo_sh_b_i | input | SH_W | Second shift term of the low threshold |
| detect_o | output | 1 | One-cycle pilot detection pulse |
| stream_o | output | max(1,clog2(NUM_STREAMS)) | Index of the reported stream |
| peak_pos_o | output | 5 | Chip position of the second peak |

## Verification
The assertions take for granted that every detection is driven by a valid sample, and that the registered thresholds move only at the code-period capture point, whatever pwr_i and the shift inputs do in between. Samples and the power estimate are assumed to stay within their declared widths, so neither the correlators nor the threshold adders wrap.

The stimulus keeps to this in several ways:
- it uses amplitudes well below full scale;
- it changes the threshold controls only between tests, followed by a flush longer than one period, except in the one test that checks the capture timing;
- it drives out-of-range data only on cycles with valid_i low.

// File: rtl/pilot_det_pkg.sv
package pilot_det_pkg;
  localparam int LFSR_W   = 5;
  localparam int CODE_LEN = (1 << LFSR_W) - 1;
  localparam int POS_W    = $clog2(CODE_LEN);
  localparam int CNT_W    = $clog2(CODE_LEN + 1);

  // maximal-length code, bit k is chip k
  function automatic logic [CODE_LEN-1:0] pilot_code();
    logic [LFSR_W-1:0]   st;
    logic                fb;
    logic [CODE_LEN-1:0] c;
    st = LFSR_W'(1);
    c  = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      c[k] = st[0];
      fb   = st[0] ^ st[2];
      st   = {fb, st[LFSR_W-1:1]};
    end
    return c;
  endfunction
endpackage

// File: rtl/pilot_det_mf.sv
module pilot_det_mf
  import pilot_det_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CORR_W   = 16,
  parameter int MAG_W    = 17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] i_i,
  input  logic signed [SAMPLE_W-1:0] q_i,
  output logic        [MAG_W-1:0]    mag_o
);
  localparam logic [CODE_LEN-1:0] CODE = pilot_code();

  logic signed [SAMPLE_W-1:0] rail_in [2];
  assign rail_in[0] = i_i;
  assign rail_in[1] = q_i;

  for (genvar r = 0; r < 2; r++) begin : g_rail
    logic signed [SAMPLE_W-1:0] hist_q [CODE_LEN-1];
    logic signed [SAMPLE_W-1:0] win    [CODE_LEN];
    logic signed [CORR_W-1:0]   acc;
    logic        [CORR_W-1:0]   abs_v;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < CODE_LEN-1; j++) hist_q[j] <= '0;
      end else if (valid_i) begin
        for (int j = 0; j < CODE_LEN-2; j++) hist_q[j] <= hist_q[j+1];
        hist_q[CODE_LEN-2] <= rail_in[r];
      end
    end

    always_comb begin
      for (int j = 0; j < CODE_LEN-1; j++) win[j] = hist_q[j];
      win[CODE_LEN-1] = rail_in[r];
    end

    always_comb begin
      acc = '0;
      for (int j = 0; j < CODE_LEN; j++) begin
        if (CODE[j]) acc = acc + CORR_W'(win[j]);
        else         acc = acc - CORR_W'(win[j]);
      end
    end

    assign abs_v = acc[CORR_W-1] ? CORR_W'(-acc) : CORR_W'(acc);
  end

  logic [MAG_W-1:0] mag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mag_q <= '0;
    else if (valid_i) mag_q <= MAG_W'(g_rail[0].abs_v) + MAG_W'(g_rail[1].abs_v);
  end
  assign mag_o = mag_q;
endmodule

// File: rtl/pilot_det_thresh.sv
module pilot_det_thresh #(
  parameter int PWR_W = 12,
  parameter int SH_W  = 4,
  parameter int THR_W = PWR_W + (1 << SH_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [SH_W-1:0]  hi_sh_a_i,
  input  logic [SH_W-1:0]  hi_sh_b_i,
  input  logic [SH_W-1:0]  lo_sh_a_i,
  input  logic [SH_W-1:0]  lo_sh_b_i,
  output logic [THR_W-1:0] hi_o,
  output logic [THR_W-1:0] lo_o
);
  function automatic logic [THR_W-1:0] scale(input logic [PWR_W-1:0] p,
                                             input logic [SH_W-1:0]  a,
                                             input logic [SH_W-1:0]  b);
    return (THR_W'(p) << a) + (THR_W'(p) << b);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (load_i) begin
      hi_o <= scale(pwr_i, hi_sh_a_i, hi_sh_b_i);
      lo_o <= scale(pwr_i, lo_sh_a_i, lo_sh_b_i);
    end
  end
endmodule

// File: rtl/pilot_det_pair.sv
module pilot_det_pair
  import pilot_det_pkg::*;
#(
  parameter int MAG_W = 17,
  parameter int THR_W = 28,
  parameter int SUM_W = 22,
  parameter int CMP_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [THR_W-1:0] hi_i,
  input  logic [THR_W-1:0] lo_i,
  output logic             hit_o
);
  logic             armed_q;
  logic [CNT_W-1:0] gap_q;
  logic [SUM_W-1:0] sum_q;
  logic             above_hi, gap_ok, at_end;

  assign above_hi = CMP_W'(mag_i) > CMP_W'(hi_i);
  assign gap_ok   = CMP_W'(sum_q) < CMP_W'(lo_i);
  assign at_end   = gap_q == CNT_W'(CODE_LEN);
  assign hit_o    = vld_i && armed_q && at_end && above_hi && gap_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
      sum_q   <= '0;
    end else if (vld_i) begin
      if (!armed_q) begin
        if (above_hi) begin
          armed_q <= 1'b1;
          gap_q   <= CNT_W'(1);
          sum_q   <= '0;
        end
      end else if (at_end) begin
        armed_q <= 1'b0;  // pass or fail, back to search
      end else begin
        gap_q <= gap_q + CNT_W'(1);
        sum_q <= sum_q + SUM_W'(mag_i);
      end
    end
  end
endmodule

// File: rtl/pilot_detector.sv
module pilot_detector
  import pilot_det_pkg::*;
#(
  parameter int NUM_STREAMS = 3,
  parameter int SAMPLE_W    = 10,
  parameter int PWR_W       = 12,
  parameter int SH_W        = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [NUM_STREAMS*SAMPLE_W-1:0] i_data_i,
  input  logic [NUM_STREAMS*SAMPLE_W-1:0] q_data_i,
  input  logic [PWR_W-1:0]                pwr_i,
  input  logic [SH_W-1:0]                 hi_sh_a_i,
  input  logic [SH_W-1:0]                 hi_sh_b_i,
  input  logic [SH_W-1:0]                 lo_sh_a_i,
  input  logic [SH_W-1:0]                 lo_sh_b_i,
  output logic                            detect_o,
  output logic [(NUM_STREAMS>1 ? $clog2(NUM_STREAMS) : 1)-1:0] stream_o,
  output logic [POS_W-1:0]                peak_pos_o
);
  localparam int CORR_W = SAMPLE_W + $clog2(CODE_LEN) + 1;
  localparam int MAG_W  = CORR_W + 1;
  localparam int SUM_W  = MAG_W + $clog2(CODE_LEN);
  localparam int THR_W  = PWR_W + (1 << SH_W);
  localparam int CMP_W  = THR_W > SUM_W ? THR_W : SUM_W;
  localparam int IDX_W  = NUM_STREAMS > 1 ? $clog2(NUM_STREAMS) : 1;

  logic [POS_W-1:0] chip_cnt_q, pos_q;
  logic             vld_q, load_en;
  logic [THR_W-1:0] hi_thr, lo_thr;
  logic [MAG_W-1:0] mag   [NUM_STREAMS];
  logic             hit   [NUM_STREAMS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_cnt_q <= '0;
      pos_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        pos_q      <= chip_cnt_q;
        chip_cnt_q <= (chip_cnt_q == POS_W'(CODE_LEN-1)) ? '0 : chip_cnt_q + POS_W'(1);
      end
    end
  end

  assign load_en = vld_q && (pos_q == POS_W'(CODE_LEN-1));

  pilot_det_thresh #(.PWR_W(PWR_W), .SH_W(SH_W), .THR_W(THR_W)) u_thr (
    .clk_i, .rst_ni, .load_i(load_en), .pwr_i,
    .hi_sh_a_i, .hi_sh_b_i, .lo_sh_a_i, .lo_sh_b_i,
    .hi_o(hi_thr), .lo_o(lo_thr)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    pilot_det_mf #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W), .MAG_W(MAG_W)) u_mf (
      .clk_i, .rst_ni, .valid_i,
      .i_i(i_data_i[s*SAMPLE_W +: SAMPLE_W]),
      .q_i(q_data_i[s*SAMPLE_W +: SAMPLE_W]),
      .mag_o(mag[s])
    );
    pilot_det_pair #(.MAG_W(MAG_W), .THR_W(THR_W), .SUM_W(SUM_W), .CMP_W(CMP_W)) u_pair (
      .clk_i, .rst_ni, .vld_i(vld_q), .mag_i(mag[s]),
      .hi_i(hi_thr), .lo_i(lo_thr), .hit_o(hit[s])
    );
  end

  // strongest second peak wins, ties keep the lower index
  logic             found;
  logic [IDX_W-1:0] best_idx;
  logic [MAG_W-1:0] best_mag;
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_mag = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (hit[s] && (!found || mag[s] > best_mag)) begin
        found    = 1'b1;
        best_idx = IDX_W'(s);
        best_mag = mag[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      detect_o   <= 1'b0;
      stream_o   <= '0;
      peak_pos_o <= '0;
    end else begin
      detect_o <= found;
      if (found) begin
        stream_o   <= best_idx;
        peak_pos_o <= pos_q;
      end
    end
  end
endmodule

// File: rtl/pilot_detector_chk.sv
module pilot_detector_chk #(
  parameter int NUM_STREAMS = 3,
  parameter int IDX_W       = 2,
  parameter int POS_W       = 5,
  parameter int CODE_LEN    = 31,
  parameter int THR_W       = 28
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             detect_i,
  input logic [IDX_W-1:0] stream_i,
  input logic [POS_W-1:0] pos_i,
  input logic             vld_i,
  input logic [POS_W-1:0] chip_pos_i,
  input logic [THR_W-1:0] hi_i,
  input logic [THR_W-1:0] lo_i
);
  // R6: a detection always follows a valid second-peak sample
  p_detect_from_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_i |-> $past(vld_i));

  // R11: reported stream exists
  p_stream_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_i |-> (int'(stream_i) < NUM_STREAMS));

  // R7: chip position stays within one code period
  p_pos_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pos_i) < CODE_LEN);

  // R10: thresholds move only at the period capture point
  p_thr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vld_i && (int'(chip_pos_i) == CODE_LEN-1)) |-> ($stable(hi_i) && $stable(lo_i)));
endmodule

bind pilot_detector pilot_detector_chk #(
  .NUM_STREAMS(NUM_STREAMS), .IDX_W(IDX_W), .POS_W(POS_W),
  .CODE_LEN(CODE_LEN), .THR_W(THR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .detect_i(detect_o), .stream_i(stream_o),
  .pos_i(peak_pos_o), .vld_i(vld_q), .chip_pos_i(pos_q), .hi_i(hi_thr), .lo_i(lo_thr)
);

// File: tb/pilot_detector_tb_top.sv
module pilot_detector_tb_top;
  localparam int NS = 3;
  localparam int W  = 10;
  localparam int PW = 12;
  localparam int SW = 4;
  localparam int CL = 31;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              valid_i;
  logic [NS*W-1:0]   i_data_i, q_data_i;
  logic [PW-1:0]     pwr_i;
  logic [SW-1:0]     hi_sh_a_i, hi_sh_b_i, lo_sh_a_i, lo_sh_b_i;
  logic              detect_o;
  logic [1:0]        stream_o;
  logic [4:0]        peak_pos_o;

  always #4 clk = ~clk;

  pilot_detector dut_i (
    .clk_i(clk), .rst_ni, .valid_i, .i_data_i, .q_data_i, .pwr_i,
    .hi_sh_a_i, .hi_sh_b_i, .lo_sh_a_i, .lo_sh_b_i,
    .detect_o, .stream_o, .peak_pos_o
  );

  int n_run = 0, n_fail = 0;
  int gsc = 0;
  int det_cnt, det_stream, det_pos, det_gsc;
  bit code [CL];
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (detect_o) begin
      det_cnt++;
      det_stream = int'(stream_o);
      det_pos    = int'(peak_pos_o);
      det_gsc    = gsc;
    end
  endtask

  task automatic clear_det();
    det_cnt = 0; det_stream = -1; det_pos = -1; det_gsc = -1;
  endtask

  task automatic send(input int i0, input int i1, input int i2,
                      input int q0, input int q1, input int q2);
    valid_i = 1'b1;
    i_data_i = {W'(i2), W'(i1), W'(i0)};
    q_data_i = {W'(q2), W'(q1), W'(q0)};
    tick();
    gsc++;
  endtask

  task automatic idle();
    valid_i  = 1'b0;
    i_data_i = {NS{W'(300)}};
    q_data_i = {NS{W'(300)}};
    tick();
  endtask

  task automatic flush(input int n);
    for (int k = 0; k < n; k++) send(0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_cfg(input int p, input int ha, input int hb, input int la, input int lb);
    pwr_i = PW'(p);
    hi_sh_a_i = SW'(ha); hi_sh_b_i = SW'(hb);
    lo_sh_a_i = SW'(la); lo_sh_b_i = SW'(lb);
    flush(70);
    clear_det();
  endtask

  task automatic send_pilot(input int i0, input int i1, input int i2,
                            input int q0, input int q1, input int q2,
                            input int reps, input bit gaps, input int extra,
                            output int start);
    start = gsc;
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k < CL; k++) begin
        int c;
        c = code[k] ? 1 : -1;
        send(i0*c, i1*c, i2*c, q0*c, q1*c, q2*c);
        if (gaps) idle();
      end
      for (int e = 0; e < extra; e++) send(0, 0, 0, 0, 0, 0);
    end
    flush(40);
  endtask

  task automatic t_reset();
    check(detect_o == 1'b0, "R1 detect after reset", int'(detect_o), 0);
    check(stream_o == 2'd0, "R1 stream after reset", int'(stream_o), 0);
    check(peak_pos_o == 5'd0, "R1 pos after reset", int'(peak_pos_o), 0);
    clear_det();
    flush(40);
    check(det_cnt == 0, "R1 no detect on silence", det_cnt, 0);
  endtask

  task automatic t_basic();
    int st;
    set_cfg(32, 2, 1, 4, 3);
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1, "R2 one detect on pilot", det_cnt, 1);
    check(det_stream == 0, "R2 stream", det_stream, 0);
    check(det_pos == (st + 61) % CL, "R7 peak position", det_pos, (st + 61) % CL);
    check(det_gsc == st + 62, "R7 detect latency", det_gsc, st + 62);
  endtask

  task automatic t_phase();
    int st;
    set_cfg(32, 2, 1, 4, 3);
    send_pilot(0, 0, 0, 0, 8, 0, 3, 0, 0, st);
    check(det_cnt == 1 && det_stream == 1, "R3 quadrature-only pilot", det_stream, 1);
    clear_det();
    send_pilot(0, 0, -6, 0, 0, -2, 3, 0, 0, st);
    check(det_cnt == 1 && det_stream == 2, "R3 rotated pilot", det_stream, 2);
  endtask

  task automatic t_hi_bound();
    int st;
    set_cfg(124, 0, 0, 1, 0);  // high 248 = peak
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 0, "R4 peak equal to high threshold", det_cnt, 0);
    set_cfg(123, 0, 0, 1, 0);  // high 246
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1, "R4 peak just above high threshold", det_cnt, 1);
  endtask

  task automatic t_lo_bound();
    int st;
    set_cfg(40, 2, 1, 2, 1);  // low 240 = gap sum
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 0, "R5 gap sum equal to low threshold", det_cnt, 0);
    set_cfg(40, 2, 1, 2, 2);  // low 320
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1, "R5 gap sum below low threshold", det_cnt, 1);
  endtask

  task automatic t_spacing();
    int st;
    set_cfg(32, 2, 1, 4, 3);
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 1, st);
    check(det_cnt == 0, "R6 peaks 32 apart", det_cnt, 0);
    clear_det();
    send_pilot(8, 0, 0, 0, 0, 0, 4, 0, 0, st);
    check(det_cnt == 2, "R6 restart after evaluation", det_cnt, 2);
    check(det_pos == (st + 123) % CL, "R6 second detection position", det_pos, (st + 123) % CL);
  endtask

  task automatic t_gaps();
    int st;
    set_cfg(32, 2, 1, 4, 3);
    send_pilot(8, 0, 0, 0, 0, 0, 3, 1, 0, st);
    check(det_cnt == 1, "R8 pilot with idle cycles", det_cnt, 1);
    check(det_pos == (st + 61) % CL, "R8 position counts valid only", det_pos, (st + 61) % CL);
  endtask

  task automatic t_scale();
    int st;
    set_cfg(64, 2, 1, 4, 3);  // high 384
    send_pilot(8, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 0, "R9 higher power blocks weak pilot", det_cnt, 0);
    clear_det();
    send_pilot(13, 0, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1, "R9 stronger pilot passes scaled threshold", det_cnt, 1);
  endtask

  task automatic t_boundary();
    int st;
    set_cfg(1000, 2, 1, 4, 3);
    while (gsc % CL != 21) send(0, 0, 0, 0, 0, 0);
    st = gsc;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < CL; k++) begin
        int c;
        c = code[k] ? 8 : -8;
        if (gsc == st + 13) pwr_i = PW'(32);
        send(c, 0, 0, 0, 0, 0);
      end
    end
    flush(40);
    check(det_cnt == 1, "R10 threshold applies from next period", det_cnt, 1);
    check(det_gsc == st + 93, "R10 detect on later peak pair", det_gsc, st + 93);
  endtask

  task automatic t_multi();
    int st;
    set_cfg(32, 2, 1, 4, 3);
    send_pilot(0, 8, 9, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1 && det_stream == 2, "R11 strongest stream", det_stream, 2);
    clear_det();
    send_pilot(8, 8, 0, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1 && det_stream == 0, "R11 tie to lowest index", det_stream, 0);
    clear_det();
    send_pilot(8, 10, 8, 0, 0, 0, 3, 0, 0, st);
    check(det_cnt == 1 && det_stream == 1, "R11 middle stream strongest", det_stream, 1);
  endtask

  initial begin
    logic [4:0] s;
    s = 5'd1;
    for (int k = 0; k < CL; k++) begin
      code[k] = s[0];
      s = {s[0] ^ s[2], s[4:1]};
    end
    rst_ni = 1'b0;
    valid_i = 1'b0;
    i_data_i = '0; q_data_i = '0;
    pwr_i = '0;
    hi_sh_a_i = '0; hi_sh_b_i = '0; lo_sh_a_i = '0; lo_sh_b_i = '0;
    clear_det();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_phase();
    t_hi_bound();
    t_lo_bound();
    t_spacing();
    t_gaps();
    t_scale();
    t_boundary();
    t_multi();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=0 expected=1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule